// File: doc/BRIEF.md
# PWM Output Software Force

This block sets the two outputs of a PWM channel, A and B, from software. A one-time force register carries, for each output, a two-bit action and a strobe bit. Writing the strobe applies the action once, in that write. The same register selects when a separate continuous-force value moves from its shadow copy to its active copy.

Each output is a registered level that resets low. A one-time force changes it once, and any later event may change it again. A single compare-event action input per output stands in for the action tables of the counter and compare logic. The time base supplies strobes for counter-at-zero and counter-at-period, which pace the shadow-to-active reload.

Top module: `pwm_swforce`

## Requirements
- R1: After reset both outputs are low. Every register field reads 0, and the active continuous-force value is 0.
- R2: Register 0 (wr_sel/rd_sel = 0) has this layout:
  - bits 7:6 are the reload mode;
  - bits 4:3 are the B action;
  - bits 1:0 are the A action;
  - bit 5 is the B strobe and bit 2 is the A strobe.
  
  The strobe bits and bits 15:8 always read 0. A write of 0xFF reads back as 0x00DB.
- R3: Writing register 0 with bit 2 set applies the A action given in bits 1:0 of that same write, on the clock edge of the write. The action codes are 0 none, 1 low, 2 high and 3 toggle.
- R4: Bit 5 with bits 4:3 does the same for B, independently of A. A write with a strobe bit at 0 forces nothing, and the compare action for that output still applies.
- R5: When a strobe and a compare action hit the same output in one cycle, the strobe wins. This holds even when the strobe's action is "none", in which case the output holds its level.
- R6: A forced level stays only until a later compare action on that output changes it.
- R7: Without a strobe, a compare action input applies each cycle with the same encoding as R3.
- R8: Reload mode 0 copies the continuous-force shadow (register 1, bits 3:0) to the active copy on a counter-zero strobe only.
- R9: Reload mode 1 copies on a counter-period strobe only.
- R10: Reload mode 2 copies on either strobe.
- R11: In reload mode 3, a write to register 1 reaches the active copy on its own clock edge, with no time-base strobe needed.
- R12: The toggle action inverts the registered level present before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 force register, 1 continuous-force shadow |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target, same coding as wr_sel |
| rd_data | output | RD_W | Read data |
| ctr_zero | input | 1 | Counter-at-zero strobe |
| ctr_prd | input | 1 | Counter-at-period strobe |
| cmp_act_a | input | 2 | Compare-event action for A |
| cmp_act_b | input | 2 | Compare-event action for B |
| csf_active | output | 4 | Active continuous-force value (B in 3:2, A in 1:0) |
| out_a | output | 1 | Output A level |
| out_b | output | 1 | Output B level |

## Verification
The bench targets collisions between a strobe and a compare action in the same cycle, including a strobe whose action is "none". A design that let the compare win there would move the output when it should hold. It checks that a write with strobe bits clear changes neither output's force path. A design that decoded the action fields alone would force on every register write. It steps each reload mode through the wrong strobe before the right one, so a swapped or ignored mode decode shows up as an early copy. Mode 3 is checked with no strobes at all.

// File: rtl/pwm_swforce.sv
module pwm_swforce #(
  parameter int RD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [7:0]      wr_data,
  input  logic            rd_sel,
  output logic [RD_W-1:0] rd_data,
  input  logic            ctr_zero,
  input  logic            ctr_prd,
  input  logic [1:0]      cmp_act_a,
  input  logic [1:0]      cmp_act_b,
  output logic [3:0]      csf_active,
  output logic            out_a,
  output logic            out_b
);

  localparam logic [1:0] ACT_NONE = 2'd0;
  localparam logic [1:0] ACT_LOW  = 2'd1;
  localparam logic [1:0] ACT_HIGH = 2'd2;
  localparam logic [1:0] RLD_ZERO = 2'd0;
  localparam logic [1:0] RLD_PRD  = 2'd1;
  localparam logic [1:0] RLD_BOTH = 2'd2;
  localparam logic [1:0] RLD_DIR  = 2'd3;

  logic [1:0] mode, act_a, act_b;
  logic [3:0] csf_sh;

  wire wr_frc = wr_en & ~wr_sel;
  wire wr_csf = wr_en & wr_sel;
  wire frc_a  = wr_frc & wr_data[2];
  wire frc_b  = wr_frc & wr_data[5];
  wire [1:0] sel_a = frc_a ? wr_data[1:0] : cmp_act_a;
  wire [1:0] sel_b = frc_b ? wr_data[4:3] : cmp_act_b;

  wire reload = (mode == RLD_ZERO && ctr_zero) ||
                (mode == RLD_PRD  && ctr_prd)  ||
                (mode == RLD_BOTH && (ctr_zero || ctr_prd));

  function automatic logic next_lvl(input logic [1:0] act, input logic cur);
    case (act)
      ACT_NONE: next_lvl = cur;
      ACT_LOW:  next_lvl = 1'b0;
      ACT_HIGH: next_lvl = 1'b1;
      default:  next_lvl = ~cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      act_a <= '0;
      act_b <= '0;
    end else if (wr_frc) begin
      mode  <= wr_data[7:6];
      act_b <= wr_data[4:3];
      act_a <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csf_sh     <= '0;
      csf_active <= '0;
    end else begin
      if (wr_csf) csf_sh <= wr_data[3:0];
      if (wr_csf && mode == RLD_DIR) csf_active <= wr_data[3:0];
      else if (reload)               csf_active <= csf_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      out_a <= next_lvl(sel_a, out_a);
      out_b <= next_lvl(sel_b, out_b);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel) rd_data[3:0] = csf_sh;
    else        rd_data[7:0] = {mode, 1'b0, act_b, 1'b0, act_a};
  end

  a_r5_force_wins_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[2] && wr_data[1:0] == ACT_HIGH) |=> out_a);

  a_r5_force_none_holds_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[5] && wr_data[4:3] == ACT_NONE) |=> $stable(out_b));

  a_r7_cmp_low_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !wr_sel && wr_data[2]) && cmp_act_a == ACT_LOW) |=> !out_a);

  a_r12_toggle_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[5] && wr_data[4:3] == 2'd3) |=> (out_b != $past(out_b)));

  a_r8_mode0_no_prd_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RLD_ZERO && !ctr_zero) |=> $stable(csf_active));

  a_r9_mode1_no_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RLD_PRD && !ctr_prd) |=> $stable(csf_active));

endmodule

// File: tb/tb_pwm_swforce.sv
module tb_pwm_swforce;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic ctr_zero = 1'b0, ctr_prd = 1'b0;
  logic [1:0] cmp_act_a = '0, cmp_act_b = '0;
  logic [15:0] rd_data;
  logic [3:0] csf_active;
  logic out_a, out_b;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pwm_swforce dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ctr_zero(ctr_zero),
    .ctr_prd(ctr_prd), .cmp_act_a(cmp_act_a), .cmp_act_b(cmp_act_b),
    .csf_active(csf_active), .out_a(out_a), .out_b(out_b));

  // {wr, data[7:0], cmpA, cmpB, expA, expB}
  localparam int NV = 11;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 8'h06, 2'd0, 2'd0, 1'b1, 1'b0},   // R3 force A high
    {1'b1, 8'h30, 2'd0, 2'd0, 1'b1, 1'b1},   // R4 force B high
    {1'b0, 8'h00, 2'd1, 2'd0, 1'b0, 1'b1},   // R7 cmp A low
    {1'b1, 8'h07, 2'd0, 2'd0, 1'b1, 1'b1},   // R12 force A toggle
    {1'b1, 8'h05, 2'd2, 2'd0, 1'b0, 1'b1},   // R5 force low beats cmp high
    {1'b0, 8'h00, 2'd3, 2'd0, 1'b1, 1'b1},   // R7 cmp toggle
    {1'b1, 8'h1A, 2'd0, 2'd1, 1'b1, 1'b0},   // R4 no strobe, cmp B applies
    {1'b1, 8'h3C, 2'd1, 2'd0, 1'b1, 1'b1},   // R5 none-strobe holds A; B toggles
    {1'b0, 8'h00, 2'd0, 2'd1, 1'b1, 1'b0},   // R6 cmp overrides forced B
    {1'b1, 8'h35, 2'd0, 2'd0, 1'b0, 1'b1},   // R3 R4 force both
    {1'b0, 8'h00, 2'd2, 2'd3, 1'b1, 1'b0}    // R6 cmp overrides both
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ctr_zero = 1'b0; ctr_prd = 1'b0;
    cmp_act_a = '0; cmp_act_b = '0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out", {14'd0, out_a, out_b}, 16'd0);
    chk("R1 active", {12'd0, csf_active}, 16'd0);
    rd_sel = 1'b0; #1 chk("R1 reg0", rd_data, 16'd0);
    rd_sel = 1'b1; #1 chk("R1 reg1", rd_data, 16'd0);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i][14]; wr_sel = 1'b0; wr_data = VEC[i][13:6];
      cmp_act_a = VEC[i][5:4]; cmp_act_b = VEC[i][3:2];
      step();
      chk($sformatf("R3-7 vec %0d", i), {14'd0, out_a, out_b}, {14'd0, VEC[i][1:0]});
    end

    wr(1'b0, 8'hFF);
    rd_sel = 1'b0; #1 chk("R2 readback", rd_data, 16'h00DB);

    wr(1'b0, 8'h00);
    wr(1'b1, 8'h09);
    chk("R8 no load on write", {12'd0, csf_active}, 16'd0);
    ctr_prd = 1'b1; step();
    chk("R8 prd ignored", {12'd0, csf_active}, 16'd0);
    ctr_zero = 1'b1; step();
    chk("R8 zero loads", {12'd0, csf_active}, 16'h9);

    wr(1'b0, 8'h40);
    wr(1'b1, 8'h06);
    ctr_zero = 1'b1; step();
    chk("R9 zero ignored", {12'd0, csf_active}, 16'h9);
    ctr_prd = 1'b1; step();
    chk("R9 prd loads", {12'd0, csf_active}, 16'h6);

    wr(1'b0, 8'h80);
    wr(1'b1, 8'h03);
    ctr_prd = 1'b1; step();
    chk("R10 prd loads", {12'd0, csf_active}, 16'h3);
    wr(1'b1, 8'h0C);
    ctr_zero = 1'b1; step();
    chk("R10 zero loads", {12'd0, csf_active}, 16'hC);

    wr(1'b0, 8'hC0);
    wr(1'b1, 8'h05);
    chk("R11 direct write", {12'd0, csf_active}, 16'h5);
    rd_sel = 1'b1; #1 chk("R11 shadow read", rd_data, 16'h5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule